// File: doc/BRIEF.md
# Subtractive-Decode I/O Bridge

This block sits between a simplified host bus and an 8-bit expansion bus and decides who owns each host I/O cycle. When a cycle starts, the bridge first checks whether the address falls in its own two-register window. If it does, the bridge claims the cycle at once and serves it from its registers. Otherwise it waits a fixed number of clocks for another target to claim the cycle. If no other target answers, the bridge takes the cycle by subtractive decoding and runs a strobed expansion-bus I/O cycle.

An address with any bit set at or above bit 16 never reaches the expansion bus. If nobody claims such a cycle, it ends with an abort flag. The bridge keeps a programmable idle gap between consecutive expansion-bus cycles. A host cycle that arrives while this gap is still running is held off. Writes are not posted: the host gets its ready only after the expansion strobe has ended. Reads return the data that was sampled on the last strobe clock.

The host presents one cycle at a time. It pulses `host_start` with the address, direction and write data. It starts the next cycle no earlier than the ready cycle, or after a foreign claim has finished.

Top module: `io_claim_bridge`

## Requirements
In the requirements below, D is DECODE_WAIT (default 3) and L is STROBE_LEN (default 4). The start pulse is sampled at edge s.

- R1: After synchronous reset, `own_devsel`, `host_ready`, `host_abort`, `isa_rd` and `isa_wr` are all low.
- R2: The register window is INT_BASE (default 0x000000E8) for the gap register and INT_BASE+1 for an 8-bit scratch register. A hit asserts `own_devsel` and `host_ready` in the cycle after edge s and starts no expansion-bus cycle. A read returns the register value. Addresses INT_BASE-1 and INT_BASE+2 are not hits.
- R3: If `peer_devsel` is high at any of edges s+1 to s+D, the bridge produces no `own_devsel`, no `host_ready`, no `host_abort` and no strobe for that cycle.
- R4: An unclaimed cycle whose address is below 0x10000 raises `own_devsel` after edge s+D. The strobe rises at edge s+D+1. `isa_addr` equals address bits 15:0, and for a write `isa_dout` equals the write data. `isa_wr` is the strobe for writes and `isa_rd` the strobe for reads.
- R5: The strobe stays high for exactly L clocks. `host_ready` is high in the first cycle after the strobe falls, so writes are not posted. A read returns the value `isa_din` had in the last strobe-high clock.
- R6: An unclaimed cycle with any address bit at 16 or above produces no strobe and no `own_devsel`. In the cycle after edge s+D it gives `host_ready` and `host_abort` together, with `host_rdata` all ones.
- R7: Let G be the gap register value when a strobe falls. The next strobe stays low for at least G+1 clocks. When the host restarts in the ready cycle, the low time is exactly max(D+2, G+1).
- R8: The gap register resets to GAP_INIT (default 8). Writes above GAP_MAX (default 100, 1 us at 100 MHz) are stored as GAP_MAX.
- R9: A cycle that starts in the ready cycle of the previous expansion cycle gets `host_ready` max(D+1, G)+L+1 cycles after its start pulse.
- R10: `isa_rd` and `isa_wr` are never high together. `isa_addr` and `isa_dout` hold steady while a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start | input | 1 | One-clock pulse marking the address phase of a host I/O cycle |
| host_addr | input | 32 | I/O address, valid with `host_start` |
| host_write | input | 1 | 1 for a write, 0 for a read |
| host_wdata | input | 8 | Write data, valid with `host_start` |
| peer_devsel | input | 1 | Claim asserted by another host-side target |
| own_devsel | output | 1 | Claim asserted by this bridge |
| host_ready | output | 1 | One-clock completion pulse for a cycle the bridge ended |
| host_abort | output | 1 | Master-abort flag, high together with `host_ready` |
| host_rdata | output | 8 | Read data, valid while `host_ready` is high |
| isa_addr | output | 16 | Expansion-bus I/O address |
| isa_dout | output | 8 | Expansion-bus write data |
| isa_din | input | 8 | Expansion-bus read data |
| isa_rd | output | 1 | Expansion-bus read strobe, active high |
| isa_wr | output | 1 | Expansion-bus write strobe, active high |

## Verification
The bench asserts a foreign claim at every clock of the decode window, for reads and writes to both low and high addresses. A bridge that samples the window one clock short or one clock long would still strobe the bus or raise its own claim. The bench sweeps the gap value from 0 to 12 with the host restarting at once, and checks both the measured low time and the ready latency. An off-by-one in the gap counter, or a cycle that is not held off, shows up directly in those counts. The read data model changes on every strobe clock, so sampling on any clock but the last returns the wrong byte. Addresses just outside the register window, addresses with high bits set, and gap writes above the limit catch a decode that is too wide and a missing clamp.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  typedef enum logic [1:0] {
    CL_IDLE,
    CL_DECODE,
    CL_WAIT,
    CL_BUSY
  } claim_st_e;

  typedef enum logic {
    ENG_IDLE,
    ENG_STROBE
  } eng_st_e;

endpackage

// File: rtl/ioc_decode.sv
module ioc_decode #(
  parameter int              ADDR_W   = 32,
  parameter int              ISA_AW   = 16,
  parameter logic [ADDR_W-1:0] INT_BASE = 'h0000_00E8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              int_hit,
  output logic              int_sel,
  output logic              above_isa
);

  assign int_hit = (addr[ADDR_W-1:1] == INT_BASE[ADDR_W-1:1]);
  assign int_sel = addr[0];

  generate
    if (ADDR_W > ISA_AW) begin : g_hi
      assign above_isa = |addr[ADDR_W-1:ISA_AW];
    end else begin : g_nohi
      assign above_isa = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ioc_regs.sv
module ioc_regs #(
  parameter int DATA_W   = 8,
  parameter int GAP_MAX  = 100,
  parameter int GAP_INIT = 8,
  parameter int GAP_W    = $clog2(GAP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [GAP_W-1:0]  gap_val,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] LIMIT_D = DATA_W'(GAP_MAX);
  localparam logic [GAP_W-1:0]  LIMIT_G = GAP_W'(GAP_MAX);
  localparam logic [GAP_W-1:0]  INIT_G  = GAP_W'(GAP_INIT);

  logic [DATA_W-1:0] scratch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_val   <= INIT_G;
      scratch_q <= '0;
    end else if (wr_en) begin
      if (sel) begin
        scratch_q <= wdata;
      end else if (wdata > LIMIT_D) begin
        gap_val <= LIMIT_G;
      end else begin
        gap_val <= wdata[GAP_W-1:0];
      end
    end
  end

  assign rd_data = sel ? scratch_q : DATA_W'(gap_val);

endmodule

// File: rtl/ioc_isa_seq.sv
module ioc_isa_seq
  import ioc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ISA_AW     = 16,
  parameter int STROBE_LEN = 4,
  parameter int GAP_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_write,
  input  logic [ISA_AW-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  input  logic [GAP_W-1:0]  gap_val,
  input  logic [DATA_W-1:0] isa_din,
  output logic              can_go,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ISA_AW-1:0] isa_addr,
  output logic [DATA_W-1:0] isa_dout,
  output logic              isa_rd,
  output logic              isa_wr
);

  localparam int SW = $clog2(STROBE_LEN + 1);
  localparam logic [SW-1:0] LAST = SW'(STROBE_LEN - 1);

  eng_st_e          st;
  logic [SW-1:0]    scnt;
  logic [GAP_W-1:0] gap_cnt;

  assign can_go = (st == ENG_IDLE) && (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      scnt     <= '0;
      gap_cnt  <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      isa_addr <= '0;
      isa_dout <= '0;
      isa_rd   <= 1'b0;
      isa_wr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - GAP_W'(1);
      case (st)
        ENG_IDLE: begin
          if (go) begin
            st       <= ENG_STROBE;
            scnt     <= '0;
            isa_addr <= go_addr;
            isa_dout <= go_data;
            isa_rd   <= ~go_write;
            isa_wr   <= go_write;
          end
        end
        ENG_STROBE: begin
          if (scnt == LAST) begin
            if (isa_rd) rdata <= isa_din;
            isa_rd  <= 1'b0;
            isa_wr  <= 1'b0;
            done    <= 1'b1;
            gap_cnt <= gap_val;
            st      <= ENG_IDLE;
          end else begin
            scnt <= scnt + SW'(1);
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/io_claim_bridge.sv
module io_claim_bridge
  import ioc_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              DATA_W      = 8,
  parameter int              ISA_AW      = 16,
  parameter int              DECODE_WAIT = 3,
  parameter int              STROBE_LEN  = 4,
  parameter int              GAP_MAX     = 100,
  parameter int              GAP_INIT    = 8,
  parameter logic [ADDR_W-1:0] INT_BASE  = 'h0000_00E8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_start,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_write,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              peer_devsel,
  output logic              own_devsel,
  output logic              host_ready,
  output logic              host_abort,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ISA_AW-1:0] isa_addr,
  output logic [DATA_W-1:0] isa_dout,
  input  logic [DATA_W-1:0] isa_din,
  output logic              isa_rd,
  output logic              isa_wr
);

  localparam int GAP_W = $clog2(GAP_MAX + 1);
  localparam int DCW   = $clog2(DECODE_WAIT + 1);
  localparam logic [DCW-1:0] DLAST = DCW'(DECODE_WAIT - 1);

  claim_st_e         st;
  logic [DCW-1:0]    dcnt;
  logic [ISA_AW-1:0] cap_addr;
  logic              cap_write;
  logic              cap_above;
  logic [DATA_W-1:0] cap_wdata;
  logic              own_devsel_q;
  logic              int_ack_q;
  logic              abort_q;
  logic [DATA_W-1:0] rdata_q;

  logic              int_hit, int_sel, above_isa;
  logic [GAP_W-1:0]  gap_val;
  logic [DATA_W-1:0] reg_rd;
  logic              eng_can_go, eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              accept, reg_wr, go;

  ioc_decode #(
    .ADDR_W  (ADDR_W),
    .ISA_AW  (ISA_AW),
    .INT_BASE(INT_BASE)
  ) u_decode (
    .addr     (host_addr),
    .int_hit  (int_hit),
    .int_sel  (int_sel),
    .above_isa(above_isa)
  );

  assign accept = host_start &&
                  ((st == CL_IDLE) || ((st == CL_BUSY) && eng_done));
  assign reg_wr = accept && int_hit && host_write;
  assign go     = (st == CL_WAIT) && eng_can_go;

  ioc_regs #(
    .DATA_W  (DATA_W),
    .GAP_MAX (GAP_MAX),
    .GAP_INIT(GAP_INIT),
    .GAP_W   (GAP_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .sel    (int_sel),
    .wdata  (host_wdata),
    .gap_val(gap_val),
    .rd_data(reg_rd)
  );

  ioc_isa_seq #(
    .DATA_W    (DATA_W),
    .ISA_AW    (ISA_AW),
    .STROBE_LEN(STROBE_LEN),
    .GAP_W     (GAP_W)
  ) u_isa (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .go_write(cap_write),
    .go_addr (cap_addr),
    .go_data (cap_wdata),
    .gap_val (gap_val),
    .isa_din (isa_din),
    .can_go  (eng_can_go),
    .done    (eng_done),
    .rdata   (eng_rdata),
    .isa_addr(isa_addr),
    .isa_dout(isa_dout),
    .isa_rd  (isa_rd),
    .isa_wr  (isa_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= CL_IDLE;
      dcnt         <= '0;
      cap_addr     <= '0;
      cap_write    <= 1'b0;
      cap_above    <= 1'b0;
      cap_wdata    <= '0;
      own_devsel_q <= 1'b0;
      int_ack_q    <= 1'b0;
      abort_q      <= 1'b0;
      rdata_q      <= '0;
    end else begin
      int_ack_q <= 1'b0;
      abort_q   <= 1'b0;
      case (st)
        CL_IDLE: own_devsel_q <= 1'b0;
        CL_DECODE: begin
          if (peer_devsel) begin
            st <= CL_IDLE;
          end else if (dcnt == DLAST) begin
            if (cap_above) begin
              abort_q <= 1'b1;
              rdata_q <= '1;
              st      <= CL_IDLE;
            end else begin
              own_devsel_q <= 1'b1;
              st           <= CL_WAIT;
            end
          end else begin
            dcnt <= dcnt + DCW'(1);
          end
        end
        CL_WAIT: if (eng_can_go) st <= CL_BUSY;
        CL_BUSY: begin
          if (eng_done) begin
            own_devsel_q <= 1'b0;
            st           <= CL_IDLE;
          end
        end
        default: st <= CL_IDLE;
      endcase
      if (accept) begin
        cap_addr  <= host_addr[ISA_AW-1:0];
        cap_write <= host_write;
        cap_above <= above_isa;
        cap_wdata <= host_wdata;
        if (int_hit) begin
          int_ack_q    <= 1'b1;
          own_devsel_q <= 1'b1;
          rdata_q      <= reg_rd;
          st           <= CL_IDLE;
        end else begin
          own_devsel_q <= 1'b0;
          dcnt         <= '0;
          st           <= CL_DECODE;
        end
      end
    end
  end

  assign own_devsel = own_devsel_q;
  assign host_ready = int_ack_q | abort_q | eng_done;
  assign host_abort = abort_q;
  assign host_rdata = eng_done ? eng_rdata : rdata_q;

endmodule

// File: rtl/ioc_checker.sv
module ioc_checker #(
  parameter int DATA_W     = 8,
  parameter int ISA_AW     = 16,
  parameter int STROBE_LEN = 4,
  parameter int GAP_W      = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              own_devsel,
  input logic              host_ready,
  input logic              host_abort,
  input logic [DATA_W-1:0] host_rdata,
  input logic [ISA_AW-1:0] isa_addr,
  input logic [DATA_W-1:0] isa_dout,
  input logic              isa_rd,
  input logic              isa_wr,
  input logic [GAP_W-1:0]  gap_val
);

  logic        strb;
  logic        prev_strb;
  logic        seen_fall;
  logic [15:0] hi_cnt;
  logic [15:0] low_cnt;
  logic [15:0] gap_at_fall;

  assign strb = isa_rd | isa_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_strb   <= 1'b0;
      seen_fall   <= 1'b0;
      hi_cnt      <= '0;
      low_cnt     <= '0;
      gap_at_fall <= '0;
    end else begin
      prev_strb <= strb;
      hi_cnt    <= strb ? hi_cnt + 16'd1 : 16'd0;
      if (strb) low_cnt <= '0;
      else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
      if (prev_strb && !strb) begin
        gap_at_fall <= 16'(gap_val);
        seen_fall   <= 1'b1;
      end
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(isa_rd && isa_wr));

  assert_bus_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (strb && prev_strb) |-> ($stable(isa_addr) && $stable(isa_dout)));

  assert_strobe_claimed_R4: assert property (@(posedge clk) disable iff (rst)
    strb |-> own_devsel);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
    (prev_strb && !strb) |-> (hi_cnt == 16'(STROBE_LEN)));

  assert_ready_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (prev_strb && !strb) |-> (host_ready && own_devsel));

  assert_gap_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (strb && !prev_strb && seen_fall) |-> (low_cnt >= gap_at_fall + 16'd1));

  assert_abort_shape_R6: assert property (@(posedge clk) disable iff (rst)
    host_abort |-> (host_ready && !own_devsel && (host_rdata == '1)));

endmodule

bind io_claim_bridge ioc_checker #(
  .DATA_W    (DATA_W),
  .ISA_AW    (ISA_AW),
  .STROBE_LEN(STROBE_LEN),
  .GAP_W     (GAP_W)
) u_ioc_checker (
  .clk       (clk),
  .rst       (rst),
  .own_devsel(own_devsel),
  .host_ready(host_ready),
  .host_abort(host_abort),
  .host_rdata(host_rdata),
  .isa_addr  (isa_addr),
  .isa_dout  (isa_dout),
  .isa_rd    (isa_rd),
  .isa_wr    (isa_wr),
  .gap_val   (gap_val)
);

// File: tb/test_io_claim_bridge.sv
module test_io_claim_bridge;

  localparam int DW  = 3;
  localparam int SL  = 4;
  localparam int GMX = 100;
  localparam int GIN = 8;
  localparam logic [31:0] BASE = 32'h0000_00E8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_start = 1'b0;
  logic [31:0] host_addr = '0;
  logic        host_write = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        peer_devsel = 1'b0;
  logic        own_devsel, host_ready, host_abort;
  logic [7:0]  host_rdata;
  logic [15:0] isa_addr;
  logic [7:0]  isa_dout;
  logic [7:0]  isa_din = '0;
  logic        isa_rd, isa_wr;

  io_claim_bridge #(
    .DECODE_WAIT(DW),
    .STROBE_LEN (SL),
    .GAP_MAX    (GMX),
    .GAP_INIT   (GIN),
    .INT_BASE   (BASE)
  ) i_io_claim_bridge (
    .clk(clk), .rst(rst), .host_start(host_start), .host_addr(host_addr),
    .host_write(host_write), .host_wdata(host_wdata), .peer_devsel(peer_devsel),
    .own_devsel(own_devsel), .host_ready(host_ready), .host_abort(host_abort),
    .host_rdata(host_rdata), .isa_addr(isa_addr), .isa_dout(isa_dout),
    .isa_din(isa_din), .isa_rd(isa_rd), .isa_wr(isa_wr)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int          r_ready_n, r_dev_n, r_rise_n, r_fall_n, r_gap, last_fall_cyc, hi;
  logic        r_abort, r_isa_rd, r_isa_wr, prev_s;
  logic [7:0]  r_rdata, r_isa_dout;
  logic [15:0] r_isa_addr;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [31:0] a, input logic w,
                           input logic [7:0] d, input int peer_at, input int lim);
    bit fin = 0;
    logic strb;
    r_ready_n = 0; r_dev_n = 0; r_rise_n = 0; r_fall_n = 0; r_gap = -1;
    r_abort = 0; r_rdata = '0; r_isa_addr = '0; r_isa_dout = '0;
    r_isa_rd = 0; r_isa_wr = 0;
    host_start = 1; host_addr = a; host_write = w; host_wdata = d;
    for (int n = 1; n <= lim && !fin; n++) begin
      @(negedge clk);
      if (n == 1) host_start = 0;
      if (own_devsel && r_dev_n == 0) r_dev_n = n;
      strb = isa_rd | isa_wr;
      if (strb && !prev_s) begin
        r_rise_n = n; r_gap = cyc - last_fall_cyc;
        r_isa_addr = isa_addr; r_isa_dout = isa_dout;
        r_isa_rd = isa_rd; r_isa_wr = isa_wr; hi = 0;
      end
      if (!strb && prev_s) begin
        r_fall_n = n; last_fall_cyc = cyc;
      end
      prev_s = strb;
      if (strb) begin
        hi++;
        isa_din = (isa_addr[7:0] ^ 8'h5A) ^ 8'(hi);
      end
      if (host_ready) begin
        r_ready_n = n; r_abort = host_abort; r_rdata = host_rdata; fin = 1;
      end
      if (n == peer_at) peer_devsel = 1;
      if (n == DW + 3) peer_devsel = 0;
    end
  endtask

  task automatic isa_cycle_checks(input logic [31:0] a, input logic w, input logic [7:0] d);
    run_cycle(a, w, d, 0, 60);
    chk("R4", "devsel cycle", r_dev_n, DW + 1);
    chk("R4", "strobe rise", r_rise_n, DW + 2);
    chk("R4", "isa address", r_isa_addr, a[15:0]);
    chk("R4", "strobe kind", {r_isa_rd, r_isa_wr}, {~w, w});
    if (w) chk("R4", "isa write data", r_isa_dout, d);
    chk("R5", "strobe length", r_fall_n - r_rise_n, SL);
    chk("R5", "ready after strobe", r_ready_n, DW + SL + 2);
    chk("R5", "no abort", r_abort, 0);
    if (!w) chk("R5", "read data last clock", r_rdata, (a[7:0] ^ 8'h5A) ^ 8'(SL));
  endtask

  task automatic reg_access(input logic sel, input logic w, input logic [7:0] d);
    run_cycle(BASE | 32'(sel), w, d, 0, 20);
    chk("R2", "register ack cycle", r_ready_n, 1);
    chk("R2", "register devsel cycle", r_dev_n, 1);
    chk("R2", "register no strobe", r_rise_n, 0);
  endtask

  initial begin
    prev_s = 0; last_fall_cyc = 0; hi = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset outputs", {own_devsel, host_ready, host_abort, isa_rd, isa_wr}, 0);

    reg_access(1'b0, 1'b0, 8'h00);
    chk("R8", "gap reset value", r_rdata, GIN);
    reg_access(1'b1, 1'b1, 8'hA7);
    reg_access(1'b1, 1'b0, 8'h00);
    chk("R2", "scratch readback", r_rdata, 8'hA7);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'd200 : (k == 1) ? 8'd100 : (k == 2) ? 8'd101 :
          (k == 3) ? 8'd255 : 8'd7;
      reg_access(1'b0, 1'b1, v);
      reg_access(1'b0, 1'b0, 8'h00);
      chk("R8", "gap clamp", r_rdata, (v > GMX) ? GMX : v);
    end
    reg_access(1'b0, 1'b1, 8'd0);

    isa_cycle_checks(BASE - 1, 1'b1, 8'h3C);
    isa_cycle_checks(BASE + 2, 1'b0, 8'h00);
    isa_cycle_checks(32'h0000_0000, 1'b0, 8'h00);
    isa_cycle_checks(32'h0000_03FF, 1'b1, 8'hC3);
    isa_cycle_checks(32'h0000_FFFF, 1'b0, 8'h00);
    isa_cycle_checks(32'h0000_0080, 1'b1, 8'h11);

    for (int h = 0; h < 4; h++) begin
      logic [31:0] a;
      a = (h == 0) ? 32'h0001_0000 : (h == 1) ? 32'h8000_00E8 :
          (h == 2) ? 32'h0002_0300 : 32'hFFFF_FFFF;
      for (int w = 0; w < 2; w++) begin
        run_cycle(a, w[0], 8'h55, 0, 30);
        chk("R6", "abort ready cycle", r_ready_n, DW + 1);
        chk("R6", "abort flag", r_abort, 1);
        chk("R6", "abort data ones", r_rdata, 8'hFF);
        chk("R6", "no strobe", r_rise_n, 0);
        chk("R6", "no devsel", r_dev_n, 0);
      end
    end

    for (int p = 1; p <= DW; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int h = 0; h < 2; h++) begin
          run_cycle(h ? 32'h0002_0300 : 32'h0000_0300, w[0], 8'h66, p, 30);
          chk("R3", "peer claim no ready", r_ready_n, 0);
          chk("R3", "peer claim no devsel", r_dev_n, 0);
          chk("R3", "peer claim no strobe", r_rise_n, 0);
        end
      end
    end

    for (int g = 0; g <= 12; g++) begin
      int lo, ex;
      reg_access(1'b0, 1'b1, 8'(g));
      run_cycle(32'h0000_0200 + 32'(g), 1'b1, 8'(g), 0, 80);
      run_cycle(32'h0000_0240 + 32'(g), 1'b0, 8'h00, 0, 80);
      lo = (DW + 2 > g + 1) ? DW + 2 : g + 1;
      ex = ((DW + 1 > g) ? DW + 1 : g) + SL + 1;
      chk("R7", "strobe low time", r_gap, lo);
      chk("R9", "held-off ready", r_ready_n, ex);
      chk("R5", "read data after gap", r_rdata, ((8'h40 + 8'(g)) ^ 8'h5A) ^ 8'(SL));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule